// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one memory read or write burst. A one-cycle start pulse brings in a starting column together with the burst length (four or eight beats) and the ordering mode (sequential or interleaved). Starting in the next cycle, the block presents one column address per clock until the burst is complete. It marks every beat with a valid strobe and flags the final beat.

The high column bits choose an aligned block of either four or eight columns. The low bits give the starting offset inside that block. Every beat wraps inside its block and never crosses into the next one. In eight-beat sequential mode the order is built from two four-beat halves: the low two bits count up, wrapping, inside the starting half, and then the same pattern repeats in the other half. In interleaved mode the offset of each beat is the starting offset XOR the beat index.

The same length and ordering apply to reads and writes. A controller places this block between its command decode and its column driver.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and whenever no burst is running, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: A `start_i` pulse sampled while no burst is running starts a burst. Beat 0 appears in the following cycle, and `valid_o` stays high for exactly 4 consecutive beats when `len8_i`=0 or 8 consecutive beats when `len8_i`=1.
- R3: `last_o` is 1 on the final beat of a burst and 0 on every other cycle.
- R4: During a four-beat burst, `col_o[9:2]` equals the starting column's bits 9:2. During an eight-beat burst, `col_o[9:3]` equals the starting column's bits 9:3.
- R5: In a four-beat sequential burst (`intlv_i`=0), beat i has `col_o[1:0]` = (start[1:0] + i) mod 4.
- R6: In an eight-beat sequential burst, beat i has `col_o[1:0]` = (start[1:0] + i) mod 4. `col_o[2]` equals start[2] for beats 0–3 and its inverse for beats 4–7.
- R7: In an interleaved burst (`intlv_i`=1), beat i has `col_o[1:0]` = start[1:0] XOR i for four beats, and `col_o[2:0]` = start[2:0] XOR i for eight beats.
- R8: A `start_i` pulse that arrives while a burst is running has no effect, including on its final beat. The current burst keeps its addresses, and no burst follows in the next cycle.
- R9: Length and ordering are captured at the accepted start. Changes on `len8_i` or `intlv_i` during a burst do not alter its addresses or its beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse for a burst |
| col_i | input | 10 | Starting column address |
| len8_i | input | 1 | Burst length: 0 = four beats, 1 = eight beats |
| intlv_i | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
Two things can meet in one cycle: the final beat of a burst and a new start pulse. The same applies to a start pulse and a change of length or ordering while a burst is in flight. The bench raises `start_i` exactly on the last beat, with a different column and different mode inputs. It then expects `valid_o` to be low in the next cycle. In some random bursts it also changes `len8_i` and `intlv_i` and pulses `start_i` in the middle of the burst. Every beat's address is compared with a value computed from the mode that was captured at the accepted start.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  localparam int unsigned OFS_W = 3;
endpackage

// File: rtl/burst_seq_rst_sync.sv
module burst_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic                 len8_i,
  input  logic                 intlv_i,
  output logic                 busy_o,
  output logic                 final_o,
  output logic [OFS_W-1:0]     beat_o,
  output logic [COL_W-1:0]     base_o,
  output order_e               ord_o
);
  localparam logic [OFS_W-1:0] LAST4 = OFS_W'(3);
  localparam logic [OFS_W-1:0] LAST8 = OFS_W'(7);

  logic               busy_q, busy_d;
  logic [OFS_W-1:0]   beat_q, beat_d;
  logic [COL_W-1:0]   base_q;
  logic               len8_q;
  order_e             ord_q;
  logic               accept;
  logic               final_beat;
  logic               beat_en;

  assign accept     = start_i && !busy_q;
  assign final_beat = busy_q && (beat_q == (len8_q ? LAST8 : LAST4));
  assign beat_en    = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (busy_q) begin
      busy_d = !final_beat;
      beat_d = beat_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (beat_en) begin
      busy_q <= busy_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len8_q <= 1'b0;
      ord_q  <= ORD_SEQ;
    end else if (accept) begin
      base_q <= col_i;
      len8_q <= len8_i;
      ord_q  <= intlv_i ? ORD_INTLV : ORD_SEQ;
    end
  end

  assign busy_o  = busy_q;
  assign final_o = final_beat;
  assign beat_o  = beat_q;
  assign base_o  = base_q;
  assign ord_o   = ord_q;
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [OFS_W-1:0] beat_i,
  input  order_e           ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [1:0] nib_ofs;
  logic       half_bit;

  // Bit 2 flips only on beats 4..7; in four-beat bursts beat_i[2] stays 0,
  // so bit 2 behaves as a fixed block bit there.
  assign half_bit = base_i[2] ^ beat_i[2];

  always_comb begin
    if (ord_i == ORD_SEQ) nib_ofs = base_i[1:0] + beat_i[1:0];
    else                  nib_ofs = base_i[1:0] ^ beat_i[1:0];
  end

  assign col_o = {base_i[COL_W-1:OFS_W], half_bit, nib_ofs};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             len8_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             rst_n_int;
  logic             busy;
  logic             final_beat;
  logic [OFS_W-1:0] beat;
  logic [COL_W-1:0] base;
  order_e           ord;
  logic [COL_W-1:0] col_raw;

  burst_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .col_i   (col_i),
    .len8_i  (len8_i),
    .intlv_i (intlv_i),
    .busy_o  (busy),
    .final_o (final_beat),
    .beat_o  (beat),
    .base_o  (base),
    .ord_o   (ord)
  );

  burst_seq_order #(.COL_W(COL_W)) u_order (
    .base_i (base),
    .beat_i (beat),
    .ord_i  (ord),
    .col_o  (col_raw)
  );

  assign valid_o = busy;
  assign last_o  = final_beat;
  assign col_o   = busy ? col_raw : '0;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (valid_o && !last_o) run_q <= run_q + 4'd1;
    else                       run_q <= '0;
  end

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R3

  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o); // R2

  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (run_q == 4'd3 || run_q == 4'd7)); // R2

  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3])); // R4

  AST_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && start_i) |=> !valid_o); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (col_o == '0 && !last_o)); // R1
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [9:0] col_i;
  logic       len8_i;
  logic       intlv_i;
  logic [9:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks;
  int errors;
  int cycles;
  bit done;

  burst_col_seq uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (col_i),
    .len8_i  (len8_i),
    .intlv_i (intlv_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [9:0] exp_col(logic [9:0] s, bit l8, bit il, int i);
    logic [2:0] b;
    logic [9:0] r;
    b = 3'(i);
    r = s;
    if (l8) r[2] = s[2] ^ b[2];
    if (il) r[1:0] = s[1:0] ^ b[1:0];
    else    r[1:0] = s[1:0] + b[1:0];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // disturb: 0 none, 1 mode/start noise mid-burst, 2 start on final beat
  task automatic burst(logic [9:0] s, bit l8, bit il, int disturb);
    int n;
    string tag;
    logic [9:0] e;
    n = l8 ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; col_i = s; len8_i = l8; intlv_i = il;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (disturb == 1) begin
        len8_i  = 1'($urandom);
        intlv_i = 1'($urandom);
        col_i   = 10'($urandom);
        start_i = 1'($urandom);
      end
      if (disturb == 2 && i == n - 1) begin
        start_i = 1'b1; col_i = ~s; len8_i = ~l8; intlv_i = ~il;
      end
      e = exp_col(s, l8, il, i);
      tag = il ? "R7" : (l8 ? "R6" : "R5");
      if (disturb == 1) tag = {tag, "/R9"};
      chk(col_o[1:0] == e[1:0] && col_o[2] == e[2], tag, col_o, e);
      if (l8) chk(col_o[9:3] == s[9:3], "R4", col_o, s);
      else    chk(col_o[9:2] == s[9:2], "R4", col_o, s);
      chk(valid_o == 1'b1, "R2", valid_o, 1);
      chk(last_o == (i == n - 1), "R3", last_o, (i == n - 1));
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b0, (disturb == 2) ? "R8" : "R2", valid_o, 0);
    chk(last_o == 1'b0, "R3", last_o, 0);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected <100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; start_i = 1'b0; col_i = '0; len8_i = 1'b0; intlv_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0, "R1", {valid_o, last_o}, 0);
    chk(col_o == 10'd0, "R1", col_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R1", valid_o, 0);

    // directed corners: wrap at block edges in every mode
    burst(10'h3FF, 1'b0, 1'b0, 0);
    burst(10'h3FF, 1'b1, 1'b0, 0);
    burst(10'h3FF, 1'b1, 1'b1, 0);
    burst(10'h0056, 1'b0, 1'b1, 0);
    burst(10'h005, 1'b1, 1'b0, 2);
    burst(10'h2A3, 1'b0, 1'b1, 2);
    burst(10'h101, 1'b1, 1'b1, 1);

    for (int k = 0; k < 300; k++)
      burst(10'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3));

    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && col_o == 10'd0, "R1", col_o, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule